// File: doc/BRIEF.md
# Horizontal Scaler Parameter Calculator

This unit turns a horizontal geometry request into the settings a horizontal video scaler needs. Software or a sequencer presents the width of the incoming line, the width wanted at the output and a left-right mirror request, then pulses `start`. The unit picks an integer prescale factor, derives a fine-scaling increment from it, selects filter coefficients and a gain attenuation step from internal tables, and picks a chroma bandwidth filter code from the increment.

The results are packed into four 32-bit register images (prescale, fine scale, gain and control) that a neighbouring register block loads as they stand. All division runs through one shared restoring shift-subtract divider, so a request takes a fixed divider time plus one cycle for each upward prescale step. A single-cycle `done` marks the result. A zero output width is reported through `err` and leaves the images as they were.

Top module: `hscale_param_calc`

## Requirements
- R1: When `out_width` is 0, `done` and `err` are both high in the cycle after the edge after the one that sampled `start`, and all four images keep their previous values.
- R2: The prescale factor p starts at floor(in/out) when in > out and at 1 otherwise. It is raised by one while floor(in/p) >= 384 with mirror set, or >= 768 with mirror clear, and is then clamped to 64. The value p-1 is written at prescale image bits 23:18.
- R3: The increment is 0x400 when in == out and p == 1, and floor(1024*in/(out*p)) + p otherwise. It occupies scale image bits 30:12, and bits 11:0 are 0. Scale image bit 31 (bypass) is 1 exactly when the increment equals 0x400.
- R4: With p == 1, prescale image bit 17 (accumulate) is 1 and bits 29:27 (attenuation index) are 0. Otherwise bit 17 is 0 and bits 29:27 hold the first position i in the list {1,2,4,8,2,4,8,16} whose value is at least the weight of table entry p-1. Weights are 16 for entries 7, 15, 31 and 63, 2 for entry 0, 4 for entries 1 and 2, and 8 for all other entries.
- R5: Prescale image bits 15:8 and 7:0 both carry the coefficient of table entry p-1, and bits 31:30, 26:24 and 16 are 0.
- R6: Gain image bits 31:24 hold 0x00 when the increment is 0x400, 0x01 when it is below 0x600, 0x11 below 0x680, 0x22 below 0x700 and 0x33 otherwise. Bits 23:0 are 0.
- R7: Control image bit 29 equals the mirror flag of the request, and all other bits are 0.
- R8: For a valid request `done` is high for exactly one cycle, after edge 47+k counted from the edge that sampled `start`, where k is the number of upward prescale steps (47 = 2·2·IN_W+3 at IN_W = 11). `err` is 0 at that point.
- R9: A `start` that arrives while a request is in progress is ignored and does not change that request's result or timing.
- R10: After reset `done` and `err` are 0 and all four images are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request pulse, sampled only when idle |
| in_width | input | IN_W | Incoming line width in pixels |
| out_width | input | IN_W | Requested output width in pixels |
| mirror | input | 1 | Left-right mirror request |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | High with `done` when the request was rejected |
| ctrl_img | output | 32 | Control register image |
| prescale_img | output | 32 | Prescale register image |
| scale_img | output | 32 | Fine scale register image |
| gain_img | output | 32 | Gain register image |

## Verification
A rejected request reports one edge after `start` is sampled. A valid one reports after 47 edges plus one edge for each upward prescale step, so the due cycle depends on the mirror flag and the widths. The bench model counts those steps with its own division loop, works out the due edge for every request, and compares `done` and `err` at every falling edge from the start pulse to one cycle past the due edge. The images are compared field by field in the cycle `done` is due, and again after a rejected request to confirm they kept their earlier values. One request has a second `start` injected mid-run, and the bench confirms that the timing and the results are not disturbed.

// File: rtl/hsc_pkg.sv
package hsc_pkg;

   localparam int INC_W   = 19;
   localparam int ROM_N   = 64;
   localparam int ROM_AW  = 6;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_QUOT,
      ST_SEARCH,
      ST_INCR,
      ST_FAULT
   } hsc_state_e;

   // filter coefficient of a prescale table entry
   function automatic logic [7:0] coeff_of(input int unsigned idx);
      int unsigned n;
      case (idx)
         0, 2, 6, 14: return 8'h00;
         1, 4, 12:    return 8'h02;
         3, 10:       return 8'h06;
         5:           return 8'h08;
         7:           return 8'h1E;
         8:           return 8'h0E;
         9:           return 8'h26;
         11:          return 8'h42;
         13:          return 8'h80;
         15:          return 8'hFE;
         default: begin
            if (idx <= 30) begin
               n = (idx - 15) / 2;
               return 8'(255 >> n) & 8'hFE;
            end else if (idx <= 48 || idx >= 63) begin
               return 8'hFE;
            end else begin
               n = (idx - 47) / 2;
               return 8'(255 >> n) & 8'hFE;
            end
         end
      endcase
   endfunction

   // weight sum of a prescale table entry
   function automatic int unsigned weight_of(input int unsigned idx);
      if (idx == 0) return 2;
      if (idx == 1 || idx == 2) return 4;
      if (idx == 7 || idx == 15 || idx == 31 || idx == 63) return 16;
      return 8;
   endfunction

   // first step position whose value reaches the weight
   function automatic logic [2:0] atten_of(input int unsigned w);
      int unsigned step;
      for (int i = 0; i < 8; i++) begin
         step = (i < 4) ? (1 << i) : (2 << (i - 4));
         if (step >= w) return 3'(i);
      end
      return 3'd7;
   endfunction

   function automatic logic [7:0] chroma_of(input logic [INC_W-1:0] inc);
      if (inc == INC_W'(1024)) return 8'h00;
      if (inc <  INC_W'(1536)) return 8'h01;
      if (inc <  INC_W'(1664)) return 8'h11;
      if (inc <  INC_W'(1792)) return 8'h22;
      return 8'h33;
   endfunction

endpackage

// File: rtl/hsc_divider.sv
module hsc_divider #(
   parameter int W = 22
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         go,
   input  logic [W-1:0] dividend,
   input  logic [W-1:0] divisor,
   output logic         fin,
   output logic [W-1:0] quotient
);

   localparam int CW = $clog2(W + 1);

   generate
      if (W < 2) begin : g_bad_width
         $error("hsc_divider: W must be at least 2");
      end
   endgenerate

   logic [W-1:0]  rem_q;
   logic [W-1:0]  dvs_q;
   logic [CW-1:0] cnt_q;
   logic [W:0]    trial;
   logic [W:0]    diff;

   assign trial = {rem_q, quotient[W-1]};
   assign diff  = trial - {1'b0, dvs_q};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rem_q    <= '0;
         dvs_q    <= '0;
         cnt_q    <= '0;
         quotient <= '0;
         fin      <= 1'b0;
      end else begin
         fin <= 1'b0;
         if (go) begin
            quotient <= dividend;
            rem_q    <= '0;
            dvs_q    <= divisor;
            cnt_q    <= CW'(W);
         end else if (cnt_q != '0) begin
            if (!diff[W]) begin
               rem_q    <= diff[W-1:0];
               quotient <= {quotient[W-2:0], 1'b1};
            end else begin
               rem_q    <= trial[W-1:0];
               quotient <= {quotient[W-2:0], 1'b0};
            end
            cnt_q <= cnt_q - CW'(1);
            if (cnt_q == CW'(1)) fin <= 1'b1;
         end
      end
   end

endmodule

// File: rtl/hsc_coef_rom.sv
module hsc_coef_rom #(
   parameter int PSC_W = 7
) (
   input  logic [PSC_W-1:0] psc,
   output logic [7:0]       coeff,
   output logic [2:0]       atten
);
   import hsc_pkg::*;

   logic [7:0]        coef_rom [ROM_N];
   logic [2:0]        att_rom  [ROM_N];
   logic [PSC_W-1:0]  psc_m1;
   logic [ROM_AW-1:0] idx;

   generate
      for (genvar g = 0; g < ROM_N; g++) begin : g_rom
         assign coef_rom[g] = coeff_of(g);
         assign att_rom[g]  = atten_of(weight_of(g));
      end
   endgenerate

   assign psc_m1 = psc - PSC_W'(1);
   assign idx    = (psc_m1 > PSC_W'(ROM_N - 1)) ? ROM_AW'(ROM_N - 1) : ROM_AW'(psc_m1);
   assign coeff  = coef_rom[idx];
   assign atten  = att_rom[idx];

endmodule

// File: rtl/hsc_pack.sv
module hsc_pack #(
   parameter int PSC_W = 7
) (
   input  logic [PSC_W-1:0]          psc,
   input  logic [hsc_pkg::INC_W-1:0] inc,
   input  logic [7:0]                coeff,
   input  logic [2:0]                atten,
   input  logic                      mirror,
   output logic [31:0]               ctrl_nxt,
   output logic [31:0]               pre_nxt,
   output logic [31:0]               scl_nxt,
   output logic [31:0]               gain_nxt
);
   import hsc_pkg::*;

   logic       accum;
   logic       bypass;
   logic [2:0] att_eff;

   assign accum   = (psc == PSC_W'(1));
   assign bypass  = (inc == INC_W'(1024));
   assign att_eff = accum ? 3'd0 : atten;

   assign pre_nxt  = (32'(att_eff) << 27)
                   | (32'(psc - PSC_W'(1)) << 18)
                   | (32'(accum) << 17)
                   | (32'(coeff) << 8)
                   |  32'(coeff);
   assign scl_nxt  = {bypass, inc, 12'd0};
   assign gain_nxt = {chroma_of(inc), 24'd0};
   assign ctrl_nxt = 32'(mirror) << 29;

endmodule

// File: rtl/hscale_param_calc.sv
module hscale_param_calc #(
   parameter int IN_W        = 11,
   parameter int PSC_MAX     = 64,
   parameter int CEIL_MIRROR = 384,
   parameter int CEIL_PLAIN  = 768
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start,
   input  logic [IN_W-1:0] in_width,
   input  logic [IN_W-1:0] out_width,
   input  logic            mirror,
   output logic            done,
   output logic            err,
   output logic [31:0]     ctrl_img,
   output logic [31:0]     prescale_img,
   output logic [31:0]     scale_img,
   output logic [31:0]     gain_img
);
   import hsc_pkg::*;

   localparam int DW       = 2 * IN_W;
   localparam int PSC_W    = $clog2(PSC_MAX) + 1;
   localparam int UNITY_SH = 10;

   generate
      if (PSC_MAX < 2 || PSC_MAX > ROM_N) begin : g_bad_psc
         $error("hscale_param_calc: PSC_MAX out of range");
      end
      if (IN_W < 4 || IN_W > 15) begin : g_bad_width
         $error("hscale_param_calc: IN_W out of range");
      end
      if (CEIL_MIRROR < 1 || CEIL_PLAIN < 1) begin : g_bad_ceil
         $error("hscale_param_calc: pixel ceilings must be positive");
      end
   endgenerate

   hsc_state_e      state;
   logic [IN_W-1:0] in_r;
   logic [IN_W-1:0] out_r;
   logic            mir_r;
   logic [IN_W-1:0] psc_r;

   logic [DW-1:0]   ceil_sel;
   logic [DW-1:0]   ceil_prod;
   logic            over_ceiling;
   logic [IN_W-1:0] psc_clamped;

   logic            div_go;
   logic [DW-1:0]   div_dividend;
   logic [DW-1:0]   div_divisor;
   logic            div_fin;
   logic [DW-1:0]   div_quot;

   logic            is_unity;
   logic [INC_W-1:0] inc_val;
   logic [7:0]      rom_coeff;
   logic [2:0]      rom_atten;
   logic [31:0]     ctrl_nxt, pre_nxt, scl_nxt, gain_nxt;

   // upward prescale search: compare against ceiling * p instead of dividing
   assign ceil_sel     = mir_r ? DW'(CEIL_MIRROR) : DW'(CEIL_PLAIN);
   assign ceil_prod    = ceil_sel * DW'(psc_r);
   assign over_ceiling = DW'(in_r) >= ceil_prod;
   assign psc_clamped  = (psc_r > IN_W'(PSC_MAX)) ? IN_W'(PSC_MAX) : psc_r;

   // one divider, two uses: in/out first, then 1024*in/(out*p)
   always_comb begin
      div_go       = 1'b0;
      div_dividend = DW'(in_width);
      div_divisor  = DW'(out_width);
      if (state == ST_IDLE) begin
         div_go = start && (out_width != '0);
      end else if (state == ST_SEARCH) begin
         div_go       = !over_ceiling;
         div_dividend = DW'(in_r) << UNITY_SH;
         div_divisor  = DW'(out_r) * DW'(psc_clamped);
      end
   end

   hsc_divider #(.W(DW)) u_div (
      .clk      (clk),
      .rst_n    (rst_n),
      .go       (div_go),
      .dividend (div_dividend),
      .divisor  (div_divisor),
      .fin      (div_fin),
      .quotient (div_quot)
   );

   assign is_unity = (in_r == out_r) && (psc_r == IN_W'(1));
   assign inc_val  = is_unity ? INC_W'(1024) : INC_W'(div_quot + DW'(psc_r));

   hsc_coef_rom #(.PSC_W(PSC_W)) u_rom (
      .psc   (PSC_W'(psc_r)),
      .coeff (rom_coeff),
      .atten (rom_atten)
   );

   hsc_pack #(.PSC_W(PSC_W)) u_pack (
      .psc      (PSC_W'(psc_r)),
      .inc      (inc_val),
      .coeff    (rom_coeff),
      .atten    (rom_atten),
      .mirror   (mir_r),
      .ctrl_nxt (ctrl_nxt),
      .pre_nxt  (pre_nxt),
      .scl_nxt  (scl_nxt),
      .gain_nxt (gain_nxt)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state        <= ST_IDLE;
         in_r         <= '0;
         out_r        <= '0;
         mir_r        <= 1'b0;
         psc_r        <= '0;
         done         <= 1'b0;
         err          <= 1'b0;
         ctrl_img     <= '0;
         prescale_img <= '0;
         scale_img    <= '0;
         gain_img     <= '0;
      end else begin
         done <= 1'b0;
         err  <= 1'b0;
         unique case (state)
            ST_IDLE: begin
               if (start) begin
                  in_r  <= in_width;
                  out_r <= out_width;
                  mir_r <= mirror;
                  state <= (out_width == '0) ? ST_FAULT : ST_QUOT;
               end
            end
            ST_QUOT: begin
               if (div_fin) begin
                  psc_r <= (in_r > out_r) ? div_quot[IN_W-1:0] : IN_W'(1);
                  state <= ST_SEARCH;
               end
            end
            ST_SEARCH: begin
               if (over_ceiling) begin
                  psc_r <= psc_r + IN_W'(1);
               end else begin
                  psc_r <= psc_clamped;
                  state <= ST_INCR;
               end
            end
            ST_INCR: begin
               if (div_fin) begin
                  ctrl_img     <= ctrl_nxt;
                  prescale_img <= pre_nxt;
                  scale_img    <= scl_nxt;
                  gain_img     <= gain_nxt;
                  done         <= 1'b1;
                  state        <= ST_IDLE;
               end
            end
            ST_FAULT: begin
               done  <= 1'b1;
               err   <= 1'b1;
               state <= ST_IDLE;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/hsc_checker.sv
module hsc_checker (
   input logic        clk,
   input logic        rst_n,
   input logic        start,
   input logic        done,
   input logic        err,
   input logic [31:0] ctrl_img,
   input logic [31:0] prescale_img,
   input logic [31:0] scale_img,
   input logic [31:0] gain_img
);

   logic run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     run <= 1'b0;
      else if (done)  run <= start;
      else if (start) run <= 1'b1;
   end

   assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_done_needs_request_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> run);

   assert_err_only_with_done_R1: assert property (@(posedge clk) disable iff (!rst_n)
      err |-> done);

   assert_fault_keeps_images_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (done && err) |-> ($stable(prescale_img) && $stable(scale_img)
                         && $stable(gain_img) && $stable(ctrl_img)));

   assert_bypass_matches_unity_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !err) |-> (scale_img[31] == (scale_img[30:12] == 19'h400))
                         && (scale_img[11:0] == 12'd0));

   assert_accum_clears_atten_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !err && prescale_img[17]) |-> ((prescale_img & 32'h38FC_0000) == 32'd0));

   assert_coeff_pair_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !err) |-> (prescale_img[15:8] == prescale_img[7:0])
                         && ((prescale_img & 32'hC701_0000) == 32'd0));

   assert_bypass_chroma_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !err) |-> (gain_img[23:0] == 24'd0)
                         && (!scale_img[31] || gain_img[31:24] == 8'h00));

   assert_ctrl_single_bit_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_img & ~32'h2000_0000) == 32'd0);

endmodule

bind hscale_param_calc hsc_checker u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .start        (start),
   .done         (done),
   .err          (err),
   .ctrl_img     (ctrl_img),
   .prescale_img (prescale_img),
   .scale_img    (scale_img),
   .gain_img     (gain_img)
);

// File: tb/tb_hscale_param_calc.sv
module tb_hscale_param_calc;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [10:0] in_width = '0;
   logic [10:0] out_width = '0;
   logic        mirror = 1'b0;
   logic        done, err;
   logic [31:0] ctrl_img, prescale_img, scale_img, gain_img;

   int n_cmp = 0;
   int n_bad = 0;

   // expected images, kept across requests
   logic [31:0] e_ctrl = '0, e_pre = '0, e_scl = '0, e_gain = '0;

   int unsigned coef_tab [64] = '{
      'h00,'h02,'h00,'h06,'h02,'h08,'h00,'h1E,'h0E,'h26,'h06,'h42,'h02,'h80,'h00,'hFE,
      'hFE,'h7E,'h7E,'h3E,'h3E,'h1E,'h1E,'h0E,'h0E,'h06,'h06,'h02,'h02,'h00,'h00,'hFE,
      'hFE,'hFE,'hFE,'hFE,'hFE,'hFE,'hFE,'hFE,'hFE,'hFE,'hFE,'hFE,'hFE,'hFE,'hFE,'hFE,
      'hFE,'h7E,'h7E,'h3E,'h3E,'h1E,'h1E,'h0E,'h0E,'h06,'h06,'h02,'h02,'h00,'h00,'hFE};
   int unsigned wt_tab [64] = '{
      2,4,4,8,8,8,8,16,8,8,8,8,8,8,8,16,
      8,8,8,8,8,8,8,8,8,8,8,8,8,8,8,16,
      8,8,8,8,8,8,8,8,8,8,8,8,8,8,8,8,
      8,8,8,8,8,8,8,8,8,8,8,8,8,8,8,16};
   int unsigned att_steps [8] = '{1, 2, 4, 8, 2, 4, 8, 16};

   hscale_param_calc dut (
      .clk          (clk),
      .rst_n        (rst_n),
      .start        (start),
      .in_width     (in_width),
      .out_width    (out_width),
      .mirror       (mirror),
      .done         (done),
      .err          (err),
      .ctrl_img     (ctrl_img),
      .prescale_img (prescale_img),
      .scale_img    (scale_img),
      .gain_img     (gain_img)
   );

   always #5 clk = ~clk;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_cmp++;
      n_bad++;
      $display("FAIL R8: watchdog expired, actual running expected finished");
      summary();
      $finish;
   end

   // one request: model, drive, compare every cycle up to the due edge and one past it
   task automatic run_req(input int unsigned iw, input int unsigned ow, input bit mr,
                          input bit intrude);
      int unsigned p, k, ceil, inc, att, coef, chroma, lat;
      bit          acc, bad;
      logic [31:0] x_pre, x_scl, x_gain, x_ctrl;
      bad = (ow == 0);
      p = 1; k = 0; inc = 0; att = 0; coef = 0; chroma = 0; acc = 0;
      if (!bad) begin
         p = (iw > ow) ? iw / ow : 1;
         ceil = mr ? 384 : 768;
         while (iw / p >= ceil) begin
            p++;
            k++;
         end
         if (p > 64) p = 64;
         if (iw == ow && p == 1) inc = 'h400;
         else inc = (1024 * iw) / (ow * p) + p;
         coef = coef_tab[p - 1];
         if (p == 1) begin
            acc = 1;
            att = 0;
         end else begin
            att = 8;
            for (int i = 7; i >= 0; i--)
               if (att_steps[i] >= wt_tab[p - 1]) att = i;
         end
         if (inc == 'h400)      chroma = 'h00;
         else if (inc < 'h600)  chroma = 'h01;
         else if (inc < 'h680)  chroma = 'h11;
         else if (inc < 'h700)  chroma = 'h22;
         else                   chroma = 'h33;
         x_pre  = (32'(att) << 27) | (32'(p - 1) << 18) | (32'(acc) << 17)
                | (32'(coef) << 8) | 32'(coef);
         x_scl  = (32'(inc == 'h400) << 31) | (32'(inc) << 12);
         x_gain = 32'(chroma) << 24;
         x_ctrl = 32'(mr) << 29;
      end else begin
         x_pre = e_pre; x_scl = e_scl; x_gain = e_gain; x_ctrl = e_ctrl;
      end
      lat = bad ? 1 : 47 + k;

      @(negedge clk);
      start     = 1'b1;
      in_width  = 11'(iw);
      out_width = 11'(ow);
      mirror    = mr;
      @(negedge clk);
      start = 1'b0;
      for (int j = 1; j <= lat + 1; j++) begin
         @(negedge clk);
         if (intrude && j == 10) begin
            start     = 1'b1;
            in_width  = 11'd5;
            out_width = 11'd0;
            mirror    = ~mr;
         end else begin
            start = 1'b0;
         end
         chk(intrude ? "R9 done timing with intruding start" : "R8 done timing",
             32'(done), 32'(j == lat));
         chk(bad ? "R1 err with done" : "R8 err low on valid request",
             32'(err), 32'(bad && j == lat));
         if (j == lat) begin
            if (bad) begin
               chk("R1 prescale image kept", prescale_img, x_pre);
               chk("R1 scale image kept",    scale_img,    x_scl);
               chk("R1 gain image kept",     gain_img,     x_gain);
               chk("R1 control image kept",  ctrl_img,     x_ctrl);
            end else begin
               chk("R2 prescale minus one field", prescale_img & 32'h00FC_0000, x_pre & 32'h00FC_0000);
               chk("R3 scale image",              scale_img,                    x_scl);
               chk("R4 accumulate and attenuation", prescale_img & 32'h3802_0000, x_pre & 32'h3802_0000);
               chk("R5 coefficients and spare bits", prescale_img & 32'hC701_FFFF, x_pre & 32'hC701_FFFF);
               chk("R6 gain image",               gain_img,                     x_gain);
               chk("R7 control image",            ctrl_img,                     x_ctrl);
            end
         end
      end
      e_pre = x_pre; e_scl = x_scl; e_gain = x_gain; e_ctrl = x_ctrl;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk("R10 done in reset", 32'(done), 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R10 done after reset",   32'(done),    32'd0);
      chk("R10 err after reset",    32'(err),     32'd0);
      chk("R10 prescale image",     prescale_img, 32'd0);
      chk("R10 scale image",        scale_img,    32'd0);
      chk("R10 gain image",         gain_img,     32'd0);
      chk("R10 control image",      ctrl_img,     32'd0);

      run_req(720, 720, 0, 0);    // unity bypass
      run_req(720, 720, 1, 0);    // mirror forces one step
      run_req(2047, 1, 0, 0);     // clamp to 64
      run_req(100, 0, 0, 0);      // rejected, images kept
      run_req(1023, 1024, 0, 0);  // formula lands on 0x400
      run_req(1500, 1000, 0, 1);  // intruding start mid-run
      run_req(640, 400, 0, 0);    // chroma 0x11
      run_req(640, 370, 0, 0);    // chroma 0x22
      run_req(640, 360, 0, 0);    // chroma 0x33
      run_req(2000, 300, 1, 0);
      run_req(1800, 100, 1, 0);
      run_req(2047, 40, 0, 0);
      run_req(1000, 30, 0, 0);
      run_req(300, 900, 1, 0);    // zoom with mirror
      run_req(2047, 2040, 1, 0);  // five search steps
      run_req(0, 5, 1, 0);        // empty input line
      run_req(50, 0, 1, 0);       // rejected again
      for (int i = 0; i < 40; i++)
         run_req(2047 - i * 37, 1 + (i * 53) % 2047, i[0], 0);
      repeat (3) begin
         @(negedge clk);
         chk("R8 done idle", 32'(done), 32'd0);
      end
      summary();
      $finish;
   end

endmodule